// File: doc/BRIEF.md
# Programmable Even Clock-Out Divider

This block derives an auxiliary clock from a reference clock. It divides by an even ratio chosen from a 4-bit code, and the output has an exact 50% duty cycle. A code N from 1 to 15 selects a division by 2N, so the output stays high for N reference cycles and then low for N reference cycles. A code of zero, or a low enable, stops the output and holds it low.

The code can be changed while the output is running. A new code is taken only at the start of an output period, which is the rising edge of the output. The period in progress therefore always completes with the ratio it started with, and no shortened pulse appears. After reset the held ratio is divide-by-8. The first period after reset or after a restart opens with a low phase of that held ratio, and the output then rises and loads the code present on its input. The output comes straight from a register clocked by the reference, so it cannot glitch.

Top module: `clkout_even_div`

## Requirements
- R1: While `rst` is high, `clk_out` is low from the first reference edge on.
- R2: With `out_en` high and a steady code N in 1..15, `clk_out` has a period of exactly 2N reference cycles.
- R3: In each such period, the high phase and the low phase each last exactly N reference cycles.
- R4: A code change takes effect only at the next rising edge of `clk_out`. The high and low phases already under way keep the old ratio, and the following period uses the new one.
- R5: When `out_en` is 0 or `div_code` is 0, `clk_out` is low from the next reference edge and stays low. The phase count restarts from zero.
- R6: Reset sets the held ratio to divide-by-8. With the output enabled, the first rising edge of `clk_out` comes on the 4th reference edge after reset is released, and the high phase that follows uses the code on `div_code`.
- R7: When the output is re-enabled after being stopped, it first stays low for half of the last loaded ratio, then rises and loads the current code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Output enable; 0 holds the output low |
| div_code | input | 4 | Half-ratio code N; ratio is 2N, 0 stops the output |
| clk_out | output | 1 | Divided 50% duty-cycle clock |

## Verification
Each of the fifteen nonzero codes is first held steady and the high and low phases are measured separately. This distinguishes a wrong ratio from an off-by-one in only one phase. Random codes in long sequences then exercise back-to-back ratio changes. Directed cases change the code one cycle into a high phase, which distinguishes a load at any toggle from a load at the rising edge only. Further directed cases stop the output through the enable and through a zero code, restart it, and assert reset while the output is running, which shows which held ratio governs the first low phase.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;

    localparam int unsigned CODE_W = 4;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t DEFAULT_CODE = code_t'(4);

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    function automatic logic code_is_off(input code_t c);
        return c == '0;
    endfunction

    function automatic logic phase_last(input code_t cnt, input code_t lim);
        return cnt == (lim - code_t'(1));
    endfunction

endpackage

// File: rtl/clkout_run_gate.sv
module clkout_run_gate
    import clkout_div_pkg::*;
(
    input  logic  en,
    input  code_t code,
    output logic  run
);
    assign run = en && !code_is_off(code);
endmodule

// File: rtl/clkout_phase_counter.sv
module clkout_phase_counter
    import clkout_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  code_t limit,
    output logic  last
);
    code_t cnt;

    assign last = run && phase_last(cnt, limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + code_t'(1);
        end
    end
endmodule

// File: rtl/clkout_ratio_hold.sv
module clkout_ratio_hold
    import clkout_div_pkg::*;
#(
    parameter code_t RESET_CODE = DEFAULT_CODE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t code_in,
    output code_t code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
        end else if (load) begin
            code_q <= code_in;
        end
    end
endmodule

// File: rtl/clkout_even_div.sv
module clkout_even_div
    import clkout_div_pkg::*;
#(
    parameter code_t RESET_CODE = DEFAULT_CODE
) (
    input  logic                clk_ref,
    input  logic                rst,
    input  logic                out_en,
    input  logic [CODE_W-1:0]   div_code,
    output logic                clk_out
);
    logic   run;
    logic   last;
    logic   load_new;
    code_t  act_code;
    phase_e phase;

    clkout_run_gate u_gate (
        .en   (out_en),
        .code (div_code),
        .run  (run)
    );

    clkout_phase_counter u_ctr (
        .clk   (clk_ref),
        .rst   (rst),
        .run   (run),
        .limit (act_code),
        .last  (last)
    );

    assign load_new = last && (phase == PH_LOW);

    clkout_ratio_hold #(
        .RESET_CODE (RESET_CODE)
    ) u_hold (
        .clk     (clk_ref),
        .rst     (rst),
        .load    (load_new),
        .code_in (div_code),
        .code_q  (act_code)
    );

    always_ff @(posedge clk_ref) begin
        if (rst || !run) begin
            phase <= PH_LOW;
        end else if (last) begin
            phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        end
    end

    assign clk_out = (phase == PH_HIGH);
endmodule

// File: rtl/clkout_even_div_chk.sv
module clkout_even_div_chk
    import clkout_div_pkg::*;
(
    input logic  clk_ref,
    input logic  rst,
    input logic  out_en,
    input code_t div_code,
    input logic  clk_out,
    input code_t act_code
);
    // R1: reset drives the output low
    p_reset_low_r1: assert property (@(posedge clk_ref)
        rst |=> !clk_out);

    // R5: a stop request forces the output low on the next edge
    p_off_low_r5: assert property (@(posedge clk_ref) disable iff (rst)
        (!out_en || div_code == '0) |=> !clk_out);

    // R4: the held ratio changes only together with a rising output
    p_code_at_rise_r4: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(act_code) |-> $rose(clk_out));

    // R2: the held ratio is never the stop code
    p_code_nonzero_r2: assert property (@(posedge clk_ref) disable iff (rst)
        act_code != '0);
endmodule

bind clkout_even_div clkout_even_div_chk chk_i (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .out_en   (out_en),
    .div_code (div_code),
    .clk_out  (clk_out),
    .act_code (act_code)
);

// File: tb/clkout_even_div_tb_top.sv
module clkout_even_div_tb_top;
    import clkout_div_pkg::*;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 150000;
    localparam int WAIT_LIMIT   = 200;

    logic  clk_ref = 1'b0;
    logic  rst     = 1'b1;
    logic  out_en  = 1'b0;
    code_t div_code = '0;
    logic  clk_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    clkout_even_div dut_i (
        .clk_ref  (clk_ref),
        .rst      (rst),
        .out_en   (out_en),
        .div_code (div_code),
        .clk_out  (clk_out)
    );

    function automatic int half_len(input code_t c);
        return int'(c);
    endfunction

    function automatic int full_len(input code_t c);
        return 2 * int'(c);
    endfunction

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance by negedges until clk_out equals lvl; n is the number of samples taken
    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk_ref);
            n++;
        end while (clk_out !== lvl && n < WAIT_LIMIT);
    endtask

    // current sample is at lvl; count samples of that level
    task automatic count_run(input logic lvl, output int n);
        n = 1;
        forever begin
            @(negedge clk_ref);
            if (clk_out !== lvl || n >= WAIT_LIMIT) break;
            n++;
        end
    endtask

    task automatic measure(input code_t c, input string tag);
        int d, hi, lo;
        div_code = c;
        wait_level(1'b0, d);
        wait_level(1'b1, d);
        count_run(1'b1, hi);
        count_run(1'b0, lo);
        check_int({tag, " R3 high phase"}, hi, half_len(c));
        check_int({tag, " R3 low phase"}, lo, half_len(c));
        check_int({tag, " R2 period"}, hi + lo, full_len(c));
    endtask

    task automatic count_low_hold(input int cycles, input string tag);
        int highs;
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk_ref);
            if (clk_out !== 1'b0) highs++;
        end
        check_int(tag, highs, 0);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk_ref);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, hi, lo, seed_dummy;
        code_t rc;
        seed_dummy = $urandom(32'd5113);

        // R1: low during reset
        out_en = 1'b1;
        div_code = code_t'(6);
        @(negedge clk_ref);
        count_low_hold(5, "R1 low in reset");

        // R6: default ratio governs first low phase
        rst = 1'b0;
        wait_level(1'b1, n);
        check_int("R6 first rise after release", n, int'(DEFAULT_CODE));
        count_run(1'b1, hi);
        check_int("R6 first high uses input code", hi, 6);

        // R2/R3: every code
        for (int c = 1; c <= 15; c++) begin
            measure(code_t'(c), $sformatf("code%0d", c));
        end

        // R2/R3: random sequence
        for (int i = 0; i < 25; i++) begin
            rc = code_t'(($urandom % 15) + 1);
            measure(rc, $sformatf("rand%0d", rc));
        end

        // R4: change one cycle into a high phase
        div_code = code_t'(3);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        div_code = code_t'(7);
        count_run(1'b1, hi);
        count_run(1'b0, lo);
        check_int("R4 old high kept", hi, 3);
        check_int("R4 old low kept", lo, 3);
        count_run(1'b1, hi);
        count_run(1'b0, lo);
        check_int("R4 new high", hi, 7);
        check_int("R4 new low", lo, 7);

        // R5: enable dropped in a high phase
        div_code = code_t'(5);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        out_en = 1'b0;
        count_low_hold(20, "R5 enable low holds output low");

        // R7: restart uses last loaded ratio (5) for low, then new code
        div_code = code_t'(2);
        out_en = 1'b1;
        wait_level(1'b1, n);
        check_int("R7 restart low length", n, 5);
        count_run(1'b1, hi);
        check_int("R7 restart high uses new code", hi, 2);

        // R5: zero code in a high phase
        div_code = code_t'(6);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        div_code = '0;
        count_low_hold(20, "R5 zero code holds output low");
        div_code = code_t'(3);
        wait_level(1'b1, n);
        check_int("R7 restart after zero code", n, 6);
        count_run(1'b1, hi);
        check_int("R7 high after zero code", hi, 3);

        // R1/R6: reset mid-run restores default ratio
        div_code = code_t'(11);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        rst = 1'b1;
        count_low_hold(3, "R1 reset mid-run");
        div_code = code_t'(9);
        rst = 1'b0;
        wait_level(1'b1, n);
        check_int("R6 default after mid-run reset", n, int'(DEFAULT_CODE));
        count_run(1'b1, hi);
        check_int("R6 high after mid-run reset", hi, 9);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule